// File: doc/BRIEF.md
# System clock oversampling ratio detector

This block sits in the system clock domain of a serial audio converter. While the converter is a timing slave, it times the externally driven frame clock (word select, one period per stereo sample) in system clock cycles and works out which of four oversampling ratios the system clock runs at: 256, 384, 512 or 768 times the sample rate. Downstream timing logic reads the 2-bit ratio code. The valid flag tells it when the code can be trusted, and the error flag tells it when the frame clock does not fit any supported ratio.

The frame clock passes through a two-flop synchroniser. A counter measures the distance between successive rising edges. A classifier maps each measurement onto the nearest ratio within a small tolerance window, and a confirmation filter only commits a ratio once two measurements in a row agree. When the converter is the timing master, the ratio is forced to 256 and detection is suspended.

Top module: `sysclk_ratio_detect`

## Requirements
- R1: After a synchronous reset, `ratio_code` is 00, `ratio_valid` is 0 and `ratio_err` is 0.
- R2: While `slave_mode` is 0, from the next clock on the outputs are `ratio_code`=00, `ratio_valid`=1 and `ratio_err`=0, whatever `ws_in` does. Returning `slave_mode` to 1 drops `ratio_valid` on the next clock, and detection restarts.
- R3: A measurement is the number of `clk` cycles between two successive rising edges of the synchronised `ws_in`. The first rising edge after reset only starts timing and yields no measurement.
- R4: The ratio code is 00 for 256, 01 for 384, 10 for 512 and 11 for 768 cycles per frame. A steady frame clock at each of these exact periods is detected with that code.
- R5: A measurement within ±TOL (default 4) cycles of a ratio is classified as that ratio. For example, 252, 380 and 388 are accepted, and alternating 380/388 keeps a 384 lock valid.
- R6: A measurement outside every window (for example 389 or 773) sets `ratio_err`, clears `ratio_valid` and leaves `ratio_code` at the last committed ratio.
- R7: `ratio_valid` rises only when a measurement classifies to the same ratio as the one immediately before it. A single measurement after reset or after an error is not enough.
- R8: A measurement that classifies to a different ratio than the previous one clears `ratio_valid` and leaves `ratio_code` unchanged. The new code appears, together with `ratio_valid`=1, when a second measurement confirms it.
- R9: The next in-window measurement after an error clears `ratio_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 1: detect from frame clock; 0: master, ratio forced to 256 |
| ws_in | input | 1 | Frame clock (word select), asynchronous to `clk` |
| ratio_code | output | 2 | Detected ratio: 00=256, 01=384, 10=512, 11=768 |
| ratio_valid | output | 1 | Ratio confirmed by two agreeing measurements (always 1 in master mode) |
| ratio_err | output | 1 | Latest measurement fitted no supported ratio |

## Verification
The assertions check on every clock that master mode forces the outputs, that the error and valid flags are never high together, that the code only moves while valid is high, that valid only rises right after an in-window classification, and that an out-of-window classification raises the error flag. The exact counting, the position and width of each tolerance window, the two-measurement confirmation sequence, and keeping the old code across a change or an error are shown only by the bench's scenarios, which drive frame clocks of chosen periods and compare the outputs after each frame.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;
  // Number of supported ratios and width of the code
  localparam int unsigned NUM_RATIOS = 4;
  localparam int unsigned CODE_W     = 2;
  localparam int unsigned RATIO_BASE = 128;

  typedef logic [CODE_W-1:0] ratio_code_t;

  // Code to cycles per frame: bit 1 doubles the base, bit 0 picks x2 or x3.
  function automatic int unsigned ratio_cycles(input int unsigned idx);
    int unsigned base;
    base = RATIO_BASE << ((idx >> 1) & 1);
    return base * (2 + (idx & 1));
  endfunction

  // One classified measurement
  typedef struct packed {
    logic        vld;
    logic        hit;
    ratio_code_t code;
  } cls_result_t;
endpackage

// File: rtl/ws_edge_sync.sv
module ws_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic ws_async,
  output logic ws_rise
);
  logic ws_meta, ws_sync, ws_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_meta <= 1'b0;
      ws_sync <= 1'b0;
      ws_prev <= 1'b0;
    end else begin
      ws_meta <= ws_async;
      ws_sync <= ws_meta;
      ws_prev <= ws_sync;
    end
  end

  assign ws_rise = ws_sync & ~ws_prev;
endmodule

// File: rtl/frame_period_counter.sv
module frame_period_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ws_rise,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             armed;
  logic [CNT_W-1:0] cnt_inc;

  // Saturating increment: a missing frame clock cannot wrap into a window
  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      armed    <= 1'b0;
      meas_vld <= 1'b0;
      meas_cnt <= '0;
    end else begin
      meas_vld <= 1'b0;
      if (ws_rise) begin
        cnt_q <= '0;
        armed <= 1'b1;
        if (armed) begin
          meas_vld <= 1'b1;
          meas_cnt <= cnt_inc;
        end
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
  import ratio_det_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned TOL   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meas_vld,
  input  logic [CNT_W-1:0] meas_cnt,
  output cls_result_t      cls
);
  logic [NUM_RATIOS-1:0] win_hit;
  int unsigned           cnt_i;

  assign cnt_i = 32'(meas_cnt);

  // One window comparator per supported ratio
  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam int unsigned CENTER = ratio_cycles(g);
    localparam int unsigned LO     = CENTER - TOL;
    localparam int unsigned HI     = CENTER + TOL;
    assign win_hit[g] = (cnt_i >= LO) && (cnt_i <= HI);
  end

  ratio_code_t hit_code;
  always_comb begin
    hit_code = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (win_hit[i]) hit_code = CODE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls <= '0;
    end else begin
      cls.vld  <= meas_vld;
      cls.hit  <= meas_vld & (|win_hit);
      cls.code <= hit_code;
    end
  end
endmodule

// File: rtl/ratio_confirm.sv
module ratio_confirm
  import ratio_det_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        slave_mode,
  input  cls_result_t cls,
  output ratio_code_t ratio_code,
  output logic        ratio_valid,
  output logic        ratio_err
);
  ratio_code_t cand_code;
  logic        cand_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_code  <= '0;
      ratio_valid <= 1'b0;
      ratio_err   <= 1'b0;
      cand_code   <= '0;
      cand_vld    <= 1'b0;
    end else if (!slave_mode) begin
      ratio_code  <= '0;
      ratio_valid <= 1'b1;
      ratio_err   <= 1'b0;
      cand_vld    <= 1'b0;
    end else begin
      // Leaving master mode: nothing is confirmed yet
      if (ratio_valid && !cand_vld && !cls.vld) ratio_valid <= 1'b0;
      if (cls.vld) begin
        if (!cls.hit) begin
          ratio_err   <= 1'b1;
          ratio_valid <= 1'b0;
          cand_vld    <= 1'b0;
        end else begin
          ratio_err <= 1'b0;
          cand_code <= cls.code;
          cand_vld  <= 1'b1;
          if (cand_vld && cand_code == cls.code) begin
            ratio_code  <= cls.code;
            ratio_valid <= 1'b1;
          end else begin
            ratio_valid <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sysclk_ratio_detect.sv
module sysclk_ratio_detect
  import ratio_det_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned TOL   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slave_mode,
  input  logic       ws_in,
  output logic [1:0] ratio_code,
  output logic       ratio_valid,
  output logic       ratio_err
);
  logic             ws_rise;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_cnt;
  cls_result_t      cls;
  logic             cls_vld, cls_hit;

  ws_edge_sync u_sync (
    .clk(clk), .rst(rst), .ws_async(ws_in), .ws_rise(ws_rise)
  );

  frame_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ws_rise(ws_rise),
    .meas_vld(meas_vld), .meas_cnt(meas_cnt)
  );

  ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .clk(clk), .rst(rst), .meas_vld(meas_vld), .meas_cnt(meas_cnt), .cls(cls)
  );

  assign cls_vld = cls.vld;
  assign cls_hit = cls.hit;

  ratio_confirm u_conf (
    .clk(clk), .rst(rst), .slave_mode(slave_mode), .cls(cls),
    .ratio_code(ratio_code), .ratio_valid(ratio_valid), .ratio_err(ratio_err)
  );
endmodule

// File: rtl/sysclk_ratio_detect_chk.sv
module sysclk_ratio_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic       slave_mode,
  input logic [1:0] ratio_code,
  input logic       ratio_valid,
  input logic       ratio_err,
  input logic       cls_vld,
  input logic       cls_hit
);
  p_master_forced_r2: assert property (@(posedge clk) disable iff (rst)
    !slave_mode |=> (ratio_code == 2'b00 && ratio_valid && !ratio_err));

  p_err_excl_valid_r6: assert property (@(posedge clk) disable iff (rst)
    ratio_err |-> !ratio_valid);

  p_miss_sets_err_r6: assert property (@(posedge clk) disable iff (rst)
    (slave_mode && cls_vld && !cls_hit) |=> ratio_err);

  p_code_moves_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (ratio_code != $past(ratio_code)) |-> ratio_valid);

  p_valid_after_hit_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(ratio_valid) && $past(slave_mode)) |-> $past(cls_vld && cls_hit));
endmodule

bind sysclk_ratio_detect sysclk_ratio_detect_chk u_chk (
  .clk(clk), .rst(rst), .slave_mode(slave_mode), .ratio_code(ratio_code),
  .ratio_valid(ratio_valid), .ratio_err(ratio_err),
  .cls_vld(cls_vld), .cls_hit(cls_hit)
);

// File: tb/sysclk_ratio_detect_test.sv
module sysclk_ratio_detect_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slave_mode = 1'b1;
  logic       ws_in = 1'b0;
  logic [1:0] ratio_code;
  logic       ratio_valid;
  logic       ratio_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysclk_ratio_detect uut (
    .clk(clk), .rst(rst), .slave_mode(slave_mode), .ws_in(ws_in),
    .ratio_code(ratio_code), .ratio_valid(ratio_valid), .ratio_err(ratio_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int code, input int vld, input int err);
    chk(req, "ratio_code",  int'(ratio_code),  code);
    chk(req, "ratio_valid", int'(ratio_valid), vld);
    chk(req, "ratio_err",   int'(ratio_err),   err);
  endtask

  // One frame of p clocks, starting with a rising edge; returns at a falling clk edge
  task automatic ws_period(input int p);
    ws_in = 1'b1;
    repeat (p/2) @(negedge clk);
    ws_in = 1'b0;
    repeat (p - p/2) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk_out("R1", 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R1", 0, 0, 0);
  endtask

  task automatic t_first_lock;
    ws_period(256);              // arming edge only
    chk_out("R3", 0, 0, 0);
    ws_period(256);              // one measurement
    chk_out("R7", 0, 0, 0);
    ws_period(256);              // second agreeing measurement
    chk_out("R4", 0, 1, 0);
  endtask

  // Change to period p: old code held until confirmed twice
  task automatic lock_to(input int p, input int new_code, input int old_code, input string req);
    ws_period(p);                // closes a frame of the old length
    ws_period(p);                // first new measurement
    chk_out("R8", old_code, (new_code == old_code) ? 1 : 0, 0);
    ws_period(p);
    chk_out(req, new_code, 1, 0);
  endtask

  task automatic t_ratios;
    lock_to(384, 1, 0, "R4");
    lock_to(512, 2, 1, "R4");
    lock_to(768, 3, 2, "R4");
  endtask

  task automatic t_tolerance;
    lock_to(388, 1, 3, "R5");
    lock_to(252, 0, 1, "R5");
    lock_to(380, 1, 0, "R5");
    for (int i = 0; i < 3; i++) begin
      ws_period(388);
      chk_out("R5", 1, 1, 0);
      ws_period(380);
      chk_out("R5", 1, 1, 0);
    end
  endtask

  task automatic t_error;
    lock_to(384, 1, 1, "R5");
    ws_period(389);              // closes a 384 frame
    ws_period(389);              // 389 measured
    chk_out("R6", 1, 0, 1);
    ws_period(384);              // second 389 measured
    chk_out("R6", 1, 0, 1);
    ws_period(384);              // good measurement
    chk_out("R9", 1, 0, 0);
    ws_period(384);
    chk_out("R7", 1, 1, 0);
    ws_period(773);
    ws_period(773);
    chk_out("R6", 1, 0, 1);
    ws_period(512);              // closes second 773
    ws_period(512);
    chk_out("R9", 1, 0, 0);
    ws_period(512);
    chk_out("R8", 2, 1, 0);
  endtask

  task automatic t_master;
    slave_mode = 1'b0;
    @(negedge clk);
    chk_out("R2", 0, 1, 0);
    ws_period(384);
    ws_period(389);
    ws_period(384);
    chk_out("R2", 0, 1, 0);
    slave_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "ratio_valid after return", int'(ratio_valid), 0);
    repeat (4) ws_period(384);
    chk_out("R2", 1, 1, 0);
  endtask

  initial begin
    t_reset();
    t_first_lock();
    t_ratios();
    t_tolerance();
    t_error();
    t_master();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule